// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

The block joins two identical eight-input interrupt controllers, a primary and a secondary, into one sixteen-line interrupt source for a processor. Lines 0 to 7 feed the primary directly. Lines 8 to 15 feed the secondary, whose interrupt output enters the primary on its cascade input, line 2. The processor sees one interrupt output and one 8-bit vector. It takes an interrupt by pulsing an acknowledge input for one cycle.

Each controller has two byte-wide register ports, a command port (address 0) and a data port (address 1). A controller must first be set up with a short sequence of setup words. After the first word, the second word and the data-port writes that follow it depend on mode bits in the first word. When setup is complete, command-port words retire in-service interrupts and select what the command port returns on reads. Data-port writes load the mask.

Both register ports and the read path are plain single-cycle accesses. Interrupt state changes on the clock edge. The interrupt output and the vector follow that state combinationally.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset, the interrupt output is low and the mask, request and in-service registers of both controllers read zero. A controller ignores data-port writes until it has received a first setup word. It raises no interrupt until its setup is complete.
- R2: A command-port write with bit 4 set is a first setup word. It is accepted in any state and restarts setup. The next data-port write is the vector-base word, whose bits 7:3 become the vector base.
- R3: After the vector-base word, setup takes the cascade-word step only when bit 1 of the first setup word is 0. Setup takes the extra-mode-word step only when bit 0 of the first setup word is 1. Each skipped step is passed over, and the controller continues to the next step or to ready.
- R4: When a controller is ready, a data-port write loads its mask, and a data-port read returns the mask. A masked line never raises the interrupt output.
- R5: A rising edge on a request line sets its request bit. A low level on the line clears that bit, which withdraws a request that has not been acknowledged. External line 2 has no effect, because the primary's line 2 carries the secondary's output.
- R6: The interrupt output is high while an unmasked request exists whose priority is above that of every in-service bit. A lower index means a higher priority. Across both controllers the order is 0, 1, then 8 to 15, then 3 to 7.
- R7: An acknowledge moves the winning request to in-service. The vector is the base from bits 7:3 of the vector-base word, joined with the 3-bit line index. For lines 8 to 15, both controllers set an in-service bit: the primary sets bit 2. The vector then uses the secondary's base and index (line − 8).
- R8: A command word with bits 4:3 = 00, bit 5 = 1 and bit 7 = 0 ends an interrupt. If bit 6 = 1, it clears the in-service bit named by bits 2:0. If bit 6 = 0, it clears the highest-priority in-service bit.
- R9: A command word with bits 4:3 = 01 and bit 1 = 1 selects the command-port read: in-service when bit 0 = 1, request when bit 0 = 0. After reset, the command port reads the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Request lines; bit n is line n |
| wr_en | input | 1 | Register write strobe |
| wr_slave | input | 1 | Write target: 0 = primary, 1 = secondary |
| wr_addr | input | 1 | Write port: 0 = command, 1 = data |
| wr_data | input | 8 | Write byte |
| rd_slave | input | 1 | Read target: 0 = primary, 1 = secondary |
| rd_addr | input | 1 | Read port: 0 = command (request or in-service), 1 = mask |
| rd_data | output | 8 | Read byte |
| cpu_int | output | 1 | Interrupt pending to the processor |
| cpu_ack | input | 1 | One-cycle interrupt acknowledge |
| cpu_vec | output | 8 | Vector of the winning line, valid while cpu_int is high |

## Verification
A sweep raises each of the fifteen usable lines on its own. It checks the vector, the in-service bit set on each side of the cascade, and the drop of the interrupt after acknowledge. This separates errors in the base, the index and the cascade routing. Paired and nested patterns (3 with 5, 1 and 5 with 9, 6 then 7 then 4) separate the priority order from the in-service blocking rule. Both end-of-interrupt forms are exercised. Setup runs under three different first words and one restart part-way through. The readback of mask and base shows which setup steps were taken. A line that is withdrawn before acknowledge, a masked line and external line 2 must all leave the output low.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [2:0] {
      ST_RESET,
      ST_BASE,
      ST_CASC,
      ST_MODE,
      ST_READY
   } init_st_e;

   // setup step that follows the vector-base word
   function automatic init_st_e after_base(input logic single, input logic need_mode);
      if (!single)      return ST_CASC;
      else if (need_mode) return ST_MODE;
      else              return ST_READY;
   endfunction

   // setup step that follows the cascade word
   function automatic init_st_e after_casc(input logic need_mode);
      return need_mode ? ST_MODE : ST_READY;
   endfunction
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      any_o = |vec_i;
      idx_o = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (vec_i[k]) idx_o = IW'(k);
      end
   end
endmodule

// File: rtl/pic_unit.sv
module pic_unit
   import pic_pkg::*;
#(
   parameter int LINES = 8,
   parameter int DW    = 8,
   parameter int IW    = $clog2(LINES),
   parameter int VB    = DW - IW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] req_i,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic             rd_addr,
   output logic [DW-1:0]    rd_data,
   input  logic             ack_i,
   output logic             int_o,
   output logic [IW-1:0]    win_o,
   output logic [VB-1:0]    vbase_o,
   output logic             ready_o,
   output logic [LINES-1:0] irr_o,
   output logic [LINES-1:0] isr_o,
   output logic [LINES-1:0] imr_o
);
   generate
      if (LINES != (1 << IW)) begin : g_bad_lines
         $error("pic_unit: LINES must be a power of two");
      end
      if (LINES > DW) begin : g_bad_width
         $error("pic_unit: LINES must not exceed DW");
      end
   endgenerate

   init_st_e         st;
   logic             cfg_single, cfg_mode;
   logic [VB-1:0]    vbase;
   logic             sel_isr;
   logic [LINES-1:0] req_q, irr, isr, imr;
   logic [LINES-1:0] irr_n, isr_n;

   logic             c_any, s_any;
   logic [IW-1:0]    c_idx, s_idx;

   pic_prio #(.N(LINES), .IW(IW)) u_cand (.vec_i(irr & ~imr), .any_o(c_any), .idx_o(c_idx));
   pic_prio #(.N(LINES), .IW(IW)) u_serv (.vec_i(isr),        .any_o(s_any), .idx_o(s_idx));

   logic cmd_wr, dat_wr, is_first, is_ocw2, is_ocw3, eoi_wr;
   assign cmd_wr   = wr_en && !wr_addr;
   assign dat_wr   = wr_en &&  wr_addr;
   assign is_first = wr_data[4];
   assign is_ocw2  = !wr_data[4] && !wr_data[3];
   assign is_ocw3  = !wr_data[4] &&  wr_data[3];
   assign eoi_wr   = cmd_wr && (st == ST_READY) && is_ocw2 && wr_data[5] && !wr_data[7];

   assign ready_o = (st == ST_READY);
   assign int_o   = ready_o && c_any && (!s_any || (c_idx < s_idx));
   assign win_o   = c_idx;
   assign vbase_o = vbase;
   assign irr_o   = irr;
   assign isr_o   = isr;
   assign imr_o   = imr;

   always_comb begin
      irr_n = (irr | (req_i & ~req_q)) & req_i;
      isr_n = isr;
      if (eoi_wr) begin
         if (wr_data[6])  isr_n[wr_data[IW-1:0]] = 1'b0;
         else if (s_any)  isr_n[s_idx] = 1'b0;
      end
      if (ack_i && int_o) begin
         irr_n[c_idx] = 1'b0;
         isr_n[c_idx] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
         irr   <= '0;
         isr   <= '0;
      end else begin
         req_q <= req_i;
         irr   <= irr_n;
         isr   <= isr_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_RESET;
         cfg_single <= 1'b0;
         cfg_mode   <= 1'b0;
         vbase      <= '0;
         imr        <= '0;
         sel_isr    <= 1'b0;
      end else if (cmd_wr && is_first) begin
         cfg_single <= wr_data[1];
         cfg_mode   <= wr_data[0];
         st         <= ST_BASE;
      end else if (cmd_wr) begin
         if (st == ST_READY && is_ocw3 && wr_data[1]) sel_isr <= wr_data[0];
      end else if (dat_wr) begin
         unique case (st)
            ST_BASE: begin
               vbase <= wr_data[DW-1:IW];
               st    <= after_base(cfg_single, cfg_mode);
            end
            ST_CASC:  st  <= after_casc(cfg_mode);
            ST_MODE:  st  <= ST_READY;
            ST_READY: imr <= wr_data[LINES-1:0];
            default:  st  <= st;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr)      rd_data[LINES-1:0] = imr;
      else if (sel_isr) rd_data[LINES-1:0] = isr;
      else              rd_data[LINES-1:0] = irr;
   end
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl #(
   parameter int LINES     = 8,
   parameter int DW        = 8,
   parameter int CASC_LINE = 2,
   parameter int IW        = $clog2(LINES),
   parameter int VB        = DW - IW,
   parameter int ALL       = 2 * LINES
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [ALL-1:0] irq_i,
   input  logic           wr_en,
   input  logic           wr_slave,
   input  logic           wr_addr,
   input  logic [DW-1:0]  wr_data,
   input  logic           rd_slave,
   input  logic           rd_addr,
   output logic [DW-1:0]  rd_data,
   output logic           cpu_int,
   input  logic           cpu_ack,
   output logic [DW-1:0]  cpu_vec
);
   generate
      if (CASC_LINE >= LINES) begin : g_bad_casc
         $error("casc_irq_ctrl: CASC_LINE out of range");
      end
   endgenerate

   logic [LINES-1:0] m_req, m_irr, m_isr, m_imr, s_irr, s_isr, s_imr;
   logic [DW-1:0]    m_rd, s_rd;
   logic             m_int, s_int, m_ready, s_ready, s_ack;
   logic [IW-1:0]    m_win, s_win;
   logic [VB-1:0]    m_vb, s_vb;

   for (genvar k = 0; k < LINES; k++) begin : g_mreq
      if (k == CASC_LINE) begin : g_casc
         assign m_req[k] = s_int;
      end else begin : g_ext
         assign m_req[k] = irq_i[k];
      end
   end

   assign s_ack = cpu_ack && m_int && (m_win == IW'(CASC_LINE));

   pic_unit #(.LINES(LINES), .DW(DW)) u_master (
      .clk(clk), .rst_n(rst_n), .req_i(m_req),
      .wr_en(wr_en && !wr_slave), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(m_rd), .ack_i(cpu_ack),
      .int_o(m_int), .win_o(m_win), .vbase_o(m_vb), .ready_o(m_ready),
      .irr_o(m_irr), .isr_o(m_isr), .imr_o(m_imr));

   pic_unit #(.LINES(LINES), .DW(DW)) u_slave (
      .clk(clk), .rst_n(rst_n), .req_i(irq_i[ALL-1:LINES]),
      .wr_en(wr_en && wr_slave), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(s_rd), .ack_i(s_ack),
      .int_o(s_int), .win_o(s_win), .vbase_o(s_vb), .ready_o(s_ready),
      .irr_o(s_irr), .isr_o(s_isr), .imr_o(s_imr));

   assign cpu_int = m_int;
   assign cpu_vec = (m_win == IW'(CASC_LINE)) ? {s_vb, s_win} : {m_vb, m_win};
   assign rd_data = rd_slave ? s_rd : m_rd;
endmodule

// File: rtl/casc_irq_ctrl_chk.sv
module casc_irq_ctrl_chk #(
   parameter int LINES     = 8,
   parameter int DW        = 8,
   parameter int CASC_LINE = 2,
   parameter int IW        = $clog2(LINES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2*LINES-1:0] irq_i,
   input logic             cpu_int,
   input logic             cpu_ack,
   input logic [DW-1:0]    cpu_vec,
   input logic             m_ready,
   input logic             s_ready,
   input logic [IW-1:0]    m_win,
   input logic [LINES-1:0] m_irr,
   input logic [LINES-1:0] m_isr,
   input logic [LINES-1:0] m_imr,
   input logic [LINES-1:0] s_irr,
   input logic [LINES-1:0] s_isr,
   input logic [LINES-1:0] s_imr
);
   localparam logic [LINES-1:0] CMASK = LINES'(1) << CASC_LINE;

   p_int_needs_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_int |-> m_ready);

   p_low_line_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((s_irr & ~$past(irq_i[2*LINES-1:LINES])) == '0) &&
               ((m_irr & ~$past(irq_i[LINES-1:0]) & ~CMASK) == '0));

   p_int_has_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_int |-> ((m_irr & ~m_imr) != '0));

   p_ack_sets_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && cpu_int) |=> m_isr[$past(m_win)]);

   p_vec_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_int && m_win != IW'(CASC_LINE)) |-> (cpu_vec[IW-1:0] == m_win));

   p_slave_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !s_ready |=> $stable(s_isr) && $stable(s_imr));
endmodule

bind casc_irq_ctrl casc_irq_ctrl_chk #(
   .LINES(LINES), .DW(DW), .CASC_LINE(CASC_LINE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .cpu_int(cpu_int), .cpu_ack(cpu_ack),
   .cpu_vec(cpu_vec), .m_ready(m_ready), .s_ready(s_ready), .m_win(m_win),
   .m_irr(m_irr), .m_isr(m_isr), .m_imr(m_imr),
   .s_irr(s_irr), .s_isr(s_isr), .s_imr(s_imr));

// File: tb/casc_irq_ctrl_bench.sv
module casc_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_i = '0;
   logic        wr_en = 1'b0, wr_slave = 1'b0, wr_addr = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        rd_slave = 1'b0, rd_addr = 1'b0;
   logic [7:0]  rd_data;
   logic        cpu_int, cpu_ack = 1'b0;
   logic [7:0]  cpu_vec;
   int          n_run = 0, n_fail = 0, cyc = 0;

   always #4 clk = ~clk;

   casc_irq_ctrl u_casc_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .wr_en(wr_en), .wr_slave(wr_slave),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_slave(rd_slave), .rd_addr(rd_addr),
      .rd_data(rd_data), .cpu_int(cpu_int), .cpu_ack(cpu_ack), .cpu_vec(cpu_vec));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic sl, input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_slave = sl; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic sl, input logic a, output logic [7:0] v);
      rd_slave = sl; rd_addr = a;
      #1 v = rd_data;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic ack();
      @(negedge clk); cpu_ack = 1'b1;
      @(negedge clk); cpu_ack = 1'b0;
   endtask

   function automatic logic [7:0] vexp(input int l);
      return (l < 8) ? (8'h20 | 8'(l)) : (8'h70 | 8'(l - 8));
   endfunction

   logic [7:0] v;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 int after reset", 32'(cpu_int), 0);
      rd(0, 1, v); chk("R1 master mask", 32'(v), 0);
      rd(1, 0, v); chk("R1 slave request", 32'(v), 0);
      irq_i[0] = 1'b1; settle();
      chk("R1 no int before setup", 32'(cpu_int), 0);
      rd(0, 0, v); chk("R9 default read is request", 32'(v), 32'h01);
      irq_i[0] = 1'b0;
      wr(0, 1, 8'hFF);
      // master: cascaded, with mode word
      wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
      rd(0, 1, v); chk("R1 pre-setup data write ignored", 32'(v), 0);
      // slave: single flag set, mode word -> cascade step skipped
      wr(1, 0, 8'h13); wr(1, 1, 8'h70); wr(1, 1, 8'h01); wr(1, 1, 8'hAA);
      rd(1, 1, v); chk("R3 cascade step skipped", 32'(v), 32'hAA);
      // R4 masked line
      irq_i[9] = 1'b1; settle();
      chk("R4 masked line no int", 32'(cpu_int), 0);
      irq_i[9] = 1'b0;
      wr(1, 1, 8'h00);
      wr(0, 0, 8'h0B); wr(1, 0, 8'h0B);
      // R7 single-line sweep
      for (int l = 0; l < 16; l++) begin
         if (l == 2) continue;
         irq_i[l] = 1'b1; settle();
         chk($sformatf("R6 int line %0d", l), 32'(cpu_int), 1);
         chk($sformatf("R7 vector line %0d", l), 32'(cpu_vec), 32'(vexp(l)));
         ack(); settle();
         chk($sformatf("R6 int blocked line %0d", l), 32'(cpu_int), 0);
         rd(0, 0, v);
         chk($sformatf("R7 master isr line %0d", l), 32'(v), (l < 8) ? (32'h1 << l) : 32'h4);
         if (l >= 8) begin
            rd(1, 0, v);
            chk($sformatf("R7 slave isr line %0d", l), 32'(v), 32'h1 << (l - 8));
         end
         irq_i[l] = 1'b0;
         if (l >= 8) wr(1, 0, 8'h20);
         wr(0, 0, 8'h20); settle();
         rd(0, 0, v); chk($sformatf("R8 nonspecific eoi line %0d", l), 32'(v), 0);
      end
      // R6 priority pair, R8 non-specific EOI exposes the next one
      irq_i[5] = 1'b1; irq_i[3] = 1'b1; settle();
      chk("R6 3 beats 5", 32'(cpu_vec), 32'h23);
      ack(); settle();
      chk("R6 5 blocked by isr 3", 32'(cpu_int), 0);
      wr(0, 0, 8'h20); settle();
      chk("R8 eoi releases 5", 32'(cpu_vec), 32'h25);
      chk("R8 int after eoi", 32'(cpu_int), 1);
      ack(); irq_i[5] = 1'b0; irq_i[3] = 1'b0;
      wr(0, 0, 8'h20); settle();
      // R6 nesting and R8 specific EOI
      irq_i[6] = 1'b1; settle(); ack();
      irq_i[7] = 1'b1; settle();
      chk("R6 lower 7 under isr 6", 32'(cpu_int), 0);
      irq_i[4] = 1'b1; settle();
      chk("R6 higher 4 nests", 32'(cpu_vec), 32'h24);
      ack(); settle();
      rd(0, 0, v); chk("R7 nested isr", 32'(v), 32'h50);
      wr(0, 0, 8'h64); settle();
      rd(0, 0, v); chk("R8 specific eoi 4", 32'(v), 32'h40);
      irq_i[4] = 1'b0; irq_i[6] = 1'b0; irq_i[7] = 1'b0;
      wr(0, 0, 8'h66); settle();
      rd(0, 0, v); chk("R8 specific eoi 6", 32'(v), 0);
      chk("R5 withdrawn 7 no int", 32'(cpu_int), 0);
      // R6 cascade position
      irq_i[5] = 1'b1; irq_i[9] = 1'b1; settle();
      chk("R6 slave 9 beats 5", 32'(cpu_vec), 32'h71);
      irq_i[1] = 1'b1; settle();
      chk("R6 1 beats slave 9", 32'(cpu_vec), 32'h21);
      irq_i[1] = 1'b0; irq_i[5] = 1'b0; irq_i[9] = 1'b0; settle();
      chk("R5 lowering withdraws all", 32'(cpu_int), 0);
      // R5 external line 2 ignored, request readback and lowering
      wr(0, 0, 8'h0A);
      irq_i[2] = 1'b1; settle();
      chk("R5 line 2 no int", 32'(cpu_int), 0);
      rd(0, 0, v); chk("R5 line 2 no request", 32'(v), 0);
      irq_i[2] = 1'b0;
      irq_i[7] = 1'b1; settle();
      rd(0, 0, v); chk("R9 request read line 7", 32'(v), 32'h80);
      irq_i[7] = 1'b0; settle();
      rd(0, 0, v); chk("R5 lowering clears request", 32'(v), 0);
      // R2 restart mid-setup, R3 mode step skipped
      wr(0, 0, 8'h11); wr(0, 1, 8'h20);
      wr(0, 0, 8'h10); wr(0, 1, 8'h40); wr(0, 1, 8'h04); wr(0, 1, 8'hFE);
      rd(0, 1, v); chk("R3 mode step skipped", 32'(v), 32'hFE);
      wr(0, 1, 8'h00);
      irq_i[0] = 1'b1; settle();
      chk("R2 new base", 32'(cpu_vec), 32'h40);
      irq_i[0] = 1'b0; settle();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule